// File: doc/BRIEF.md
# Wave lane swizzle crossbar

This block rearranges a 64-lane vector of 32-bit values, split into four rows of 16 lanes. Each cycle it takes a source vector, the destination's current (old) contents, a 9-bit control code, a per-row write mask, a per-bank write mask (a bank is 4 lanes of a row, the same mask for every row) and a bound-control bit. Every result lane gets one of three values: the value of a chosen source lane in its own row, zero, or its old destination value.

The control code picks one pattern: quad permute, row shift left, row shift right, row rotate right, full-row mirror or half-row mirror. The masks only decide which lanes are written. Reads are never gated. An unknown code leaves the whole vector unchanged and raises an error pulse. The result is registered, and `valid_out` follows `valid_in` one cycle later.

Top module: `lane_swizzle_xbar`

## Requirements
- R1: A result lane only ever takes data from a lane in its own 16-lane row (row r covers lanes 16r..16r+15, position p = lane mod 16).
- R2: Control 0x000-0x0FF is quad permute: position p takes quad slot ctrl[2q+1:2q] of its own 4-lane quad, where q = p mod 4 (0x1B reverses each quad).
- R3: Control 0x101-0x10F shifts left by n = ctrl[3:0]: position p reads position p+n. If p+n > 15 the lane has no source.
- R4: Control 0x111-0x11F shifts right by n = ctrl[3:0]: position p reads position p-n. If p-n < 0 the lane has no source.
- R5: Control 0x121-0x12F rotates right by n = ctrl[3:0]: position p reads position (p-n) mod 16.
- R6: Control 0x140 reads position 15-p. Control 0x141 reads position 8*(p/8) + 7-(p mod 8).
- R7: An enabled lane with no source gets zero when bound_zero is 1 and keeps its old value when bound_zero is 0.
- R8: row_mask bit r cleared: every lane of row r keeps its old value.
- R9: bank_mask bit b cleared: positions 4b..4b+3 of every row keep their old value. Disabled lanes can still be read by enabled lanes.
- R10: Any other control code (for example 0x100, 0x110, 0x120, 0x130, 0x142) keeps every lane's old value and sets err_out for exactly the one result cycle.
- R11: The result for an input accepted with valid_in appears with valid_out one clock later. While valid_in is low, res_vec holds and valid_out and err_out are low.
- R12: During and after reset, valid_out, err_out and res_vec are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Inputs present this cycle |
| ctrl | input | 9 | Swizzle pattern code |
| row_mask | input | 4 | Write enable, one bit per 16-lane row |
| bank_mask | input | 4 | Write enable, one bit per 4-lane bank, shared by all rows |
| bound_zero | input | 1 | 1: lanes with no source are zeroed; 0: they keep their old value |
| src_vec | input | 2048 | Source lanes, lane i at bits [32i+31:32i] |
| old_vec | input | 2048 | Old destination lanes, same layout |
| valid_out | output | 1 | Result registered this cycle |
| err_out | output | 1 | Unknown control code seen on the accepted input |
| res_vec | output | 2048 | Registered result lanes |

## Verification
Write masking and the bound rule can act on the same lane in the same cycle. A shifted lane with no source that also sits in a disabled row or bank must keep its old value, and must not be zeroed. The bench sets this up by running shifts with bound_zero set while row and bank masks are partly cleared. It also sweeps all 512 control codes with masks and the bound bit varying from cycle to cycle. Each result is compared lane by lane against a behavioural model that applies the masks before the bound rule.

// File: rtl/swz_pkg.sv
`timescale 1ns/1ps
package swz_pkg;
    localparam int CTRL_W     = 9;
    localparam int QUAD_LANES = 4;

    typedef enum logic [2:0] {
        SWZ_QUAD,
        SWZ_SHL,
        SWZ_SHR,
        SWZ_ROR,
        SWZ_MIR,
        SWZ_HMIR,
        SWZ_BAD
    } swz_mode_e;

    typedef struct packed {
        swz_mode_e  mode;
        logic [7:0] arg;
    } swz_cmd_t;
endpackage

// File: rtl/swz_decode.sv
`timescale 1ns/1ps
module swz_decode
    import swz_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output swz_cmd_t          cmd,
    output logic              bad
);
    always_comb begin
        cmd.arg  = ctrl[7:0];
        cmd.mode = SWZ_BAD;
        if (!ctrl[CTRL_W-1]) begin
            cmd.mode = SWZ_QUAD;
        end else if (ctrl[3:0] != 4'h0 && ctrl[7:4] == 4'h0) begin
            cmd.mode = SWZ_SHL;
        end else if (ctrl[3:0] != 4'h0 && ctrl[7:4] == 4'h1) begin
            cmd.mode = SWZ_SHR;
        end else if (ctrl[3:0] != 4'h0 && ctrl[7:4] == 4'h2) begin
            cmd.mode = SWZ_ROR;
        end else if (ctrl[7:0] == 8'h40) begin
            cmd.mode = SWZ_MIR;
        end else if (ctrl[7:0] == 8'h41) begin
            cmd.mode = SWZ_HMIR;
        end
        bad = (cmd.mode == SWZ_BAD);
    end
endmodule

// File: rtl/swz_lane_pick.sv
`timescale 1ns/1ps
module swz_lane_pick
    import swz_pkg::*;
#(
    parameter int ROW_LANES = 16,
    parameter int POS       = 0
) (
    input  swz_cmd_t                       cmd,
    output logic [$clog2(ROW_LANES)-1:0]   src_pos,
    output logic                           has_src
);
    localparam int PW    = $clog2(ROW_LANES);
    localparam int HALF  = ROW_LANES / 2;
    localparam int QOFF  = POS % QUAD_LANES;
    localparam int QBASE = POS - QOFF;
    localparam int MIRP  = ROW_LANES - 1 - POS;
    localparam int HMIRP = (POS / HALF) * HALF + (HALF - 1 - (POS % HALF));

    always_comb begin
        int n;
        int s;
        logic ok;
        n  = int'(cmd.arg[3:0]);
        s  = POS;
        ok = 1'b1;
        unique case (cmd.mode)
            SWZ_QUAD: s = QBASE + int'(cmd.arg[2*QOFF +: 2]);
            SWZ_SHL: begin
                s  = POS + n;
                ok = (s < ROW_LANES);
            end
            SWZ_SHR: begin
                s  = POS - n;
                ok = (s >= 0);
            end
            SWZ_ROR:  s = (POS - n + ROW_LANES) % ROW_LANES;
            SWZ_MIR:  s = MIRP;
            SWZ_HMIR: s = HMIRP;
            default:  ok = 1'b0;
        endcase
        src_pos = ok ? PW'(s) : '0;
        has_src = ok;
    end
endmodule

// File: rtl/swz_row_mux.sv
`timescale 1ns/1ps
module swz_row_mux #(
    parameter int ROW_LANES  = 16,
    parameter int BANK_LANES = 4,
    parameter int DATA_W     = 32
) (
    input  logic [ROW_LANES-1:0][DATA_W-1:0]             src_row,
    input  logic [ROW_LANES-1:0][DATA_W-1:0]             old_row,
    input  logic [ROW_LANES-1:0][$clog2(ROW_LANES)-1:0]  src_pos,
    input  logic [ROW_LANES-1:0]                         has_src,
    input  logic                                         row_en,
    input  logic [ROW_LANES/BANK_LANES-1:0]              bank_mask,
    input  logic                                         bound_zero,
    input  logic                                         bad,
    output logic [ROW_LANES-1:0][DATA_W-1:0]             new_row
);
    always_comb begin
        for (int p = 0; p < ROW_LANES; p++) begin
            if (!row_en || !bank_mask[p / BANK_LANES] || bad) begin
                new_row[p] = old_row[p];
            end else if (has_src[p]) begin
                new_row[p] = src_row[src_pos[p]];
            end else begin
                new_row[p] = bound_zero ? '0 : old_row[p];
            end
        end
    end
endmodule

// File: rtl/lane_swizzle_xbar.sv
`timescale 1ns/1ps
module lane_swizzle_xbar
    import swz_pkg::*;
#(
    parameter int LANES      = 64,
    parameter int DATA_W     = 32,
    parameter int ROW_LANES  = 16,
    parameter int BANK_LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        valid_in,
    input  logic [CTRL_W-1:0]           ctrl,
    input  logic [LANES/ROW_LANES-1:0]  row_mask,
    input  logic [ROW_LANES/BANK_LANES-1:0] bank_mask,
    input  logic                        bound_zero,
    input  logic [LANES*DATA_W-1:0]     src_vec,
    input  logic [LANES*DATA_W-1:0]     old_vec,
    output logic                        valid_out,
    output logic                        err_out,
    output logic [LANES*DATA_W-1:0]     res_vec
);
    localparam int ROWS  = LANES / ROW_LANES;
    localparam int PW    = $clog2(ROW_LANES);
    localparam int RW    = ROW_LANES * DATA_W;
    localparam int VW    = LANES * DATA_W;

    typedef struct packed {
        logic          valid;
        logic          err;
        logic [VW-1:0] res;
    } out_state_t;

    swz_cmd_t                        cmd;
    logic                            cmd_bad;
    logic [ROW_LANES-1:0][PW-1:0]    pick_pos;
    logic [ROW_LANES-1:0]            pick_ok;
    logic [VW-1:0]                   next_vec;
    out_state_t                      st_d, st_q;

    swz_decode u_decode (
        .ctrl (ctrl),
        .cmd  (cmd),
        .bad  (cmd_bad)
    );

    // One source-position selector per row position; shared by every row.
    for (genvar p = 0; p < ROW_LANES; p++) begin : g_pick
        swz_lane_pick #(
            .ROW_LANES (ROW_LANES),
            .POS       (p)
        ) u_pick (
            .cmd     (cmd),
            .src_pos (pick_pos[p]),
            .has_src (pick_ok[p])
        );
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        swz_row_mux #(
            .ROW_LANES  (ROW_LANES),
            .BANK_LANES (BANK_LANES),
            .DATA_W     (DATA_W)
        ) u_row (
            .src_row    (src_vec[r*RW +: RW]),
            .old_row    (old_vec[r*RW +: RW]),
            .src_pos    (pick_pos),
            .has_src    (pick_ok),
            .row_en     (row_mask[r]),
            .bank_mask  (bank_mask),
            .bound_zero (bound_zero),
            .bad        (cmd_bad),
            .new_row    (next_vec[r*RW +: RW])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_in;
        st_d.err   = valid_in && cmd_bad;
        if (valid_in) begin
            st_d.res = next_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_out = st_q.valid;
    assign err_out   = st_q.err;
    assign res_vec   = st_q.res;

    AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        err_out |-> valid_out);                                             // R10
    AST_BAD_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && cmd_bad) |=> (err_out && res_vec == $past(old_vec)));  // R10
    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);                                            // R11
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> (!valid_out && !err_out));                            // R11
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(res_vec));                                    // R11
endmodule

// File: tb/test_lane_swizzle_xbar.sv
`timescale 1ns/1ps
module test_lane_swizzle_xbar;
    localparam int L = 64;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_in = 1'b0;
    logic [8:0]    ctrl = '0;
    logic [3:0]    row_mask = '0;
    logic [3:0]    bank_mask = '0;
    logic          bound_zero = 1'b0;
    logic [L*W-1:0] src_vec = '0;
    logic [L*W-1:0] old_vec = '0;
    logic          valid_out;
    logic          err_out;
    logic [L*W-1:0] res_vec;

    int total = 0;
    int bad = 0;
    logic          exp_valid = 1'b0;
    logic          exp_err = 1'b0;
    logic [L*W-1:0] exp_res = '0;
    string         exp_tag = "R12";

    always #5 clk = ~clk;

    lane_swizzle_xbar i_lane_swizzle_xbar (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .ctrl(ctrl),
        .row_mask(row_mask), .bank_mask(bank_mask), .bound_zero(bound_zero),
        .src_vec(src_vec), .old_vec(old_vec), .valid_out(valid_out),
        .err_out(err_out), .res_vec(res_vec)
    );

    // Behavioural model: one lane's result.
    function automatic logic [W-1:0] model(int lane, logic [8:0] c, logic [3:0] rm,
                                           logic [3:0] bm, logic bz,
                                           logic [L*W-1:0] s, logic [L*W-1:0] o);
        int row = lane / 16;
        int p = lane % 16;
        int n = int'(c[3:0]);
        int from = -1;
        logic [W-1:0] oldv = o[lane*W +: W];
        if (c < 9'h100) from = (p / 4) * 4 + int'((c >> (2 * (p % 4))) & 9'h3);
        else if (c >= 9'h101 && c <= 9'h10F) from = (p + n <= 15) ? p + n : 99;
        else if (c >= 9'h111 && c <= 9'h11F) from = (p - n >= 0) ? p - n : 99;
        else if (c >= 9'h121 && c <= 9'h12F) from = (p + 16 - n) % 16;
        else if (c == 9'h140) from = 15 - p;
        else if (c == 9'h141) from = (p < 8) ? 7 - p : 23 - p;
        if (from < 0) return oldv;                 // unknown code
        if (!rm[row] || !bm[p / 4]) return oldv;   // write masked
        if (from == 99) return bz ? '0 : oldv;     // no source
        return s[(row * 16 + from) * W +: W];
    endfunction

    function automatic string tag_of(logic [8:0] c, logic [3:0] rm, logic [3:0] bm, logic bz);
        string t;
        if (!((c < 9'h100) || (c >= 9'h101 && c <= 9'h10F) || (c >= 9'h111 && c <= 9'h11F) ||
              (c >= 9'h121 && c <= 9'h12F) || c == 9'h140 || c == 9'h141)) return "R10";
        if (c < 9'h100) t = "R2";
        else if (c <= 9'h10F) t = bz ? "R1/R3/R7" : "R3/R7";
        else if (c <= 9'h11F) t = "R4/R7";
        else if (c <= 9'h12F) t = "R1/R5";
        else t = "R6";
        if (rm != 4'hF) t = {t, "/R8"};
        if (bm != 4'hF) t = {t, "/R9"};
        return t;
    endfunction

    task automatic check_now();
        total++;
        if (valid_out !== exp_valid || err_out !== exp_err) begin
            bad++;
            $display("FAIL %s valid/err actual=%b/%b expected=%b/%b", exp_tag,
                     valid_out, err_out, exp_valid, exp_err);
        end else if (res_vec !== exp_res) begin
            bad++;
            for (int i = 0; i < L; i++) begin
                if (res_vec[i*W +: W] !== exp_res[i*W +: W]) begin
                    $display("FAIL %s lane %0d actual=0x%08h expected=0x%08h", exp_tag, i,
                             res_vec[i*W +: W], exp_res[i*W +: W]);
                    break;
                end
            end
        end
    endtask

    // Check last cycle's result, then drive a new input and predict its result.
    task automatic step(logic v, logic [8:0] c, logic [3:0] rm, logic [3:0] bm,
                        logic bz, int pat, logic [W-1:0] oseed);
        @(negedge clk);
        check_now();
        valid_in = v; ctrl = c; row_mask = rm; bank_mask = bm; bound_zero = bz;
        for (int i = 0; i < L; i++) begin
            src_vec[i*W +: W] = (pat == 0) ? W'(10 * i + 3) : W'(i * 32'h9E3779B1) ^ W'(pat);
            old_vec[i*W +: W] = oseed ^ W'(i << 20);
        end
        if (v) begin
            exp_valid = 1'b1;
            exp_tag = tag_of(c, rm, bm, bz);
            exp_err = (exp_tag == "R10");
            for (int i = 0; i < L; i++) exp_res[i*W +: W] = model(i, c, rm, bm, bz, src_vec, old_vec);
        end else begin
            exp_valid = 1'b0; exp_err = 1'b0; exp_tag = "R11";
        end
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check_now();                                      // R12 reset state
        rst_n = 1'b1;
        step(1, 9'h01B, 4'hF, 4'hF, 1, 0, 32'hDEADBEEF);  // R2 reverse quads
        step(1, 9'h0E4, 4'hF, 4'hF, 1, 0, 32'hDEADBEEF);  // R2 identity
        step(1, 9'h039, 4'hF, 4'hF, 1, 5, 32'hDEADBEEF);  // R2
        step(1, 9'h101, 4'hF, 4'hF, 1, 0, 32'hDEADBEEF);  // R3 + R7 zero
        step(1, 9'h10F, 4'hF, 4'hF, 0, 0, 32'h12345678);  // R3 + R7 keep
        step(1, 9'h111, 4'hF, 4'hF, 1, 0, 32'hDEADBEEF);  // R4
        step(1, 9'h118, 4'hF, 4'hF, 0, 7, 32'hCAFEF00D);  // R4 + R7 keep
        step(1, 9'h121, 4'hF, 4'hF, 1, 0, 32'hDEADBEEF);  // R5
        step(1, 9'h12F, 4'hF, 4'hF, 1, 9, 32'hDEADBEEF);  // R5
        step(1, 9'h140, 4'hF, 4'hF, 1, 0, 32'hDEADBEEF);  // R6 mirror
        step(1, 9'h141, 4'hF, 4'hF, 1, 0, 32'hDEADBEEF);  // R6 half mirror
        step(1, 9'h101, 4'h5, 4'hF, 1, 0, 32'hDEADBEEF);  // R8 row mask
        step(1, 9'h101, 4'hF, 4'h5, 1, 0, 32'hDEADBEEF);  // R9 bank mask
        step(1, 9'h101, 4'hF, 4'hD, 1, 0, 32'hDEADBEEF);  // R9 lane 3 reads masked lane 4
        step(1, 9'h10C, 4'h9, 4'h6, 1, 3, 32'h0BADF00D);  // R7 vs R8/R9 same lane
        step(1, 9'h100, 4'hF, 4'hF, 1, 0, 32'h5A5A5A5A);  // R10
        step(1, 9'h142, 4'hF, 4'hF, 1, 0, 32'hA5A5A5A5);  // R10
        step(1, 9'h130, 4'hF, 4'hF, 1, 0, 32'h01010101);  // R10
        step(0, 9'h01B, 4'hF, 4'hF, 1, 11, 32'h77777777); // R11 idle holds
        step(0, 9'h100, 4'hF, 4'hF, 1, 12, 32'h66666666); // R11 no error when idle
        for (int c = 0; c < 512; c++) begin               // all codes, R1..R10
            step(1, 9'(c), 4'(c * 7 + 15), 4'(c * 5 + 15), c[0], c + 1, 32'(c * 32'h01000193));
        end
        step(0, 9'h000, 4'hF, 4'hF, 0, 0, 32'h0);
        @(negedge clk);
        check_now();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule